// File: doc/BRIEF.md
# Serial Flash Register Command Slave

This block is the register-access front end of a serial NOR flash target. It watches chip select, the serial clock and up to four data lanes, and accepts commands on one, two or four lanes as chosen by a lane-mode input. It recognises four commands: setting the write enable latch, writing the extended address register, writing one of a set of per-sector lock registers, and reading one of those lock registers. Erase and program engines are outside the block and show up only through a busy input.

A register write takes effect only when the write enable latch is already set and chip select rises exactly on the byte boundary that ends the command. A lock register carries a write-lock bit and a lock-down bit. Once the lock-down bit is set, that register ignores writes until reset. A lock read keeps sending the selected byte for as long as the serial clock runs. The serial pins are sampled by a faster system clock, and each serial clock half period must last at least two system clock cycles.

Top module: `flash_reg_slave`

## Requirements
- R1: After reset the write enable latch is 0, the extended address register is 0x00, every lock register reads 0x00 and all four lane enables are 0.
- R2: With cs_n low, input bits are taken on rising sck edges, most significant bit first. lane_mode 00 uses dq_in[0]. lane_mode 01 uses dq_in[1:0], with dq_in[1] the more significant bit. lane_mode 10 uses dq_in[3:0], with dq_in[3] the most significant. lane_mode 11 behaves like 00.
- R3: Opcode 0x06, followed by cs_n rising right after its eighth bit, sets the write enable latch.
- R4: Opcode 0xC5 with exactly one data byte, sent while the latch is set, loads that byte into the extended address register and clears the latch. Sent while the latch is clear, it changes nothing.
- R5: If cs_n rises partway through a byte, or after a byte count other than the command's exact length, the write is dropped and the latch keeps its value.
- R6: Opcode 0xE5 with three address bytes and one data byte (five bytes in all), sent while the latch is set, copies data bits 1:0 into the lock register selected by address bits 23:20 (the top nibble of the first address byte) and clears the latch. Data bits 7:2 are dropped, and bits 7:2 of every lock register read back as 0.
- R7: When bit 1 (lock-down) of the selected lock register is 1, a lock write leaves that register unchanged but still clears the latch. The lock-down bit is cleared only by reset.
- R8: Opcode 0xE8 with three address bytes makes the block send the selected lock register, most significant bit first. Each new group of bits is driven after a falling sck edge. A single-lane read uses dq_out[1], a dual-lane read uses dq_out[1:0] and a quad-lane read uses dq_out[3:0]. The byte repeats for as long as sck keeps toggling.
- R9: dq_oe is 0000 whenever cs_n is high and outside the read data phase. During the read data phase it is 0010 in single mode, 0011 in dual mode and 1111 in quad mode.
- R10: A command whose opcode is received while busy is high is ignored. It changes no register and produces no read output.
- R11: An opcode other than 0x06, 0xC5, 0xE5 or 0xE8 is ignored, together with every bit that follows it, until cs_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| dq_in | input | 4 | Serial data lanes, input side |
| lane_mode | input | 2 | 00 single, 01 dual, 10 quad, 11 single |
| busy | input | 1 | High while an erase, program or write is running |
| dq_out | output | 4 | Serial data lanes, output side |
| dq_oe | output | 4 | Per-lane output enable |
| wel | output | 1 | Write enable latch |
| ext_addr | output | 8 | Extended address register |

## Verification
The pins are sampled on every system clock. The latch and the extended address register change on the first clock edge that sees cs_n high, so they are due one edge after chip select rises. A read output group is due on the clock edge that first sees sck low after it was high, and the enables drop in the same cycle that cs_n goes high, because they are gated by it. The bench drives inputs two nanoseconds after a rising edge and runs a behavioural model that observes the same edges. It compares the model with every output at each falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/flash_reg_pkg.sv
package flash_reg_pkg;

   typedef enum logic [1:0] {
      LANE_X1  = 2'b00,
      LANE_X2  = 2'b01,
      LANE_X4  = 2'b10,
      LANE_ALT = 2'b11
   } lane_mode_e;

   localparam logic [7:0] OP_SET_WEL   = 8'h06;
   localparam logic [7:0] OP_WR_EXTADR = 8'hC5;
   localparam logic [7:0] OP_WR_LOCK   = 8'hE5;
   localparam logic [7:0] OP_RD_LOCK   = 8'hE8;

   function automatic logic [2:0] lane_width(input lane_mode_e m);
      case (m)
         LANE_X2: lane_width = 3'd2;
         LANE_X4: lane_width = 3'd4;
         default: lane_width = 3'd1;
      endcase
   endfunction

   function automatic logic [3:0] lane_mask(input lane_mode_e m);
      case (m)
         LANE_X2: lane_mask = 4'b0011;
         LANE_X4: lane_mask = 4'b1111;
         default: lane_mask = 4'b0010;
      endcase
   endfunction

   function automatic logic op_known(input logic [7:0] op);
      op_known = (op == OP_SET_WEL) || (op == OP_WR_EXTADR) ||
                 (op == OP_WR_LOCK) || (op == OP_RD_LOCK);
   endfunction

endpackage

// File: rtl/sfr_rx_frame.sv
module sfr_rx_frame
   import flash_reg_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sck_rise,
   input  lane_mode_e       mode,
   input  logic [3:0]       dq_in,
   output logic             byte_done,
   output logic [7:0]       byte_data,
   output logic [CNT_W-1:0] byte_idx,
   output logic [CNT_W-1:0] nbytes,
   output logic             on_boundary
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [7:0] shreg, shreg_nxt;
   logic [2:0] bit_cnt;
   logic [3:0] bit_sum;

   always_comb begin
      case (mode)
         LANE_X2: shreg_nxt = {shreg[5:0], dq_in[1:0]};
         LANE_X4: shreg_nxt = {shreg[3:0], dq_in};
         default: shreg_nxt = {shreg[6:0], dq_in[0]};
      endcase
      bit_sum = {1'b0, bit_cnt} + {1'b0, lane_width(mode)};
   end

   assign on_boundary = (bit_cnt == 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bit_cnt   <= '0;
         nbytes    <= '0;
         byte_done <= 1'b0;
         byte_data <= '0;
         byte_idx  <= '0;
      end else if (cs_n) begin
         bit_cnt   <= '0;
         nbytes    <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (sck_rise) begin
            shreg   <= shreg_nxt;
            bit_cnt <= bit_sum[2:0];
            if (bit_sum[3]) begin
               byte_done <= 1'b1;
               byte_data <= shreg_nxt;
               byte_idx  <= nbytes;
               if (nbytes != CNT_MAX) nbytes <= nbytes + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sfr_reg_ctrl.sv
module sfr_reg_ctrl
   import flash_reg_pkg::*;
#(
   parameter int NUM_SECTORS = 16,
   parameter int ADDR_BYTES  = 3,
   parameter int CNT_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             cs_rise,
   input  logic             busy,
   input  logic             byte_done,
   input  logic [7:0]       byte_data,
   input  logic [CNT_W-1:0] byte_idx,
   input  logic [CNT_W-1:0] nbytes,
   input  logic             on_boundary,
   output logic             wel,
   output logic [7:0]       ext_addr,
   output logic             rd_active,
   output logic [7:0]       rd_byte
);
   localparam int SECT_BITS = $clog2(NUM_SECTORS);
   localparam logic [CNT_W-1:0] IDX_ADDR0 = CNT_W'(1);
   localparam logic [CNT_W-1:0] IDX_ALAST = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] IDX_LDATA = CNT_W'(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] LEN_WEL   = CNT_W'(1);
   localparam logic [CNT_W-1:0] LEN_EXT   = CNT_W'(2);
   localparam logic [CNT_W-1:0] LEN_LOCK  = CNT_W'(ADDR_BYTES + 2);

   logic [7:0]           cmd;
   logic                 cmd_ok;
   logic [SECT_BITS-1:0] sector;
   logic [7:0]           wdata;
   logic [1:0]           lock_q [NUM_SECTORS];
   logic                 frame_ok, do_wel, do_ext, do_lock;

   assign frame_ok = cs_rise && cmd_ok && on_boundary;
   assign do_wel   = frame_ok && (cmd == OP_SET_WEL)   && (nbytes == LEN_WEL);
   assign do_ext   = frame_ok && wel && (cmd == OP_WR_EXTADR) && (nbytes == LEN_EXT);
   assign do_lock  = frame_ok && wel && (cmd == OP_WR_LOCK)   && (nbytes == LEN_LOCK);

   for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_lock
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lock_q[s] <= 2'b00;
         else if (do_lock && (sector == SECT_BITS'(s)) && !lock_q[s][1])
            lock_q[s] <= wdata[1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel       <= 1'b0;
         ext_addr  <= '0;
         cmd       <= '0;
         cmd_ok    <= 1'b0;
         sector    <= '0;
         wdata     <= '0;
         rd_active <= 1'b0;
         rd_byte   <= '0;
      end else begin
         if (do_wel)                 wel <= 1'b1;
         else if (do_ext || do_lock) wel <= 1'b0;
         if (do_ext) ext_addr <= wdata;
         if (cs_n) begin
            cmd_ok    <= 1'b0;
            rd_active <= 1'b0;
         end else if (byte_done) begin
            if (byte_idx == '0) begin
               cmd    <= byte_data;
               cmd_ok <= !busy && op_known(byte_data);
            end
            if (byte_idx == IDX_ADDR0) sector <= byte_data[7 -: SECT_BITS];
            if (((cmd == OP_WR_EXTADR) && (byte_idx == IDX_ADDR0)) ||
                ((cmd == OP_WR_LOCK) && (byte_idx == IDX_LDATA)))
               wdata <= byte_data;
            if (cmd_ok && (cmd == OP_RD_LOCK) && (byte_idx == IDX_ALAST)) begin
               rd_active <= 1'b1;
               rd_byte   <= {6'b0, lock_q[sector]};
            end
         end
      end
   end
endmodule

// File: rtl/sfr_tx_lanes.sv
module sfr_tx_lanes
   import flash_reg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck_fall,
   input  lane_mode_e mode,
   input  logic       rd_active,
   input  logic [7:0] rd_byte,
   output logic [3:0] dq_q,
   output logic [3:0] oe_q
);
   logic [2:0] ptr;
   logic [7:0] aligned;
   logic [3:0] chunk;

   always_comb begin
      aligned = rd_byte << ptr;
      case (mode)
         LANE_X2: chunk = {2'b00, aligned[7:6]};
         LANE_X4: chunk = aligned[7:4];
         default: chunk = {2'b00, aligned[7], 1'b0};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         dq_q <= '0;
         oe_q <= '0;
      end else if (cs_n || !rd_active) begin
         ptr  <= '0;
         oe_q <= '0;
      end else if (sck_fall) begin
         dq_q <= chunk;
         oe_q <= lane_mask(mode);
         ptr  <= ptr + lane_width(mode);
      end
   end
endmodule

// File: rtl/flash_reg_slave.sv
module flash_reg_slave
   import flash_reg_pkg::*;
#(
   parameter int NUM_SECTORS = 16,
   parameter int ADDR_BYTES  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic [3:0] dq_in,
   input  logic [1:0] lane_mode,
   input  logic       busy,
   output logic [3:0] dq_out,
   output logic [3:0] dq_oe,
   output logic       wel,
   output logic [7:0] ext_addr
);
   localparam int CNT_W = $clog2(ADDR_BYTES + 3);

   if (NUM_SECTORS < 2 || NUM_SECTORS > 256 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0) begin : g_bad_sectors
      $error("NUM_SECTORS must be a power of two from 2 to 256");
   end
   if (ADDR_BYTES < 2 || ADDR_BYTES > 4) begin : g_bad_addr
      $error("ADDR_BYTES must be 2, 3 or 4");
   end

   lane_mode_e       mode;
   logic             sck_q, cs_q, sck_rise, sck_fall, cs_rise;
   logic             byte_done, on_boundary, rd_active;
   logic [7:0]       byte_data, rd_byte;
   logic [CNT_W-1:0] byte_idx, nbytes;
   logic [3:0]       oe_q;

   assign mode     = lane_mode_e'(lane_mode);
   assign sck_rise = !cs_n && sck && !sck_q;
   assign sck_fall = !cs_n && !sck && sck_q;
   assign cs_rise  = cs_n && !cs_q;
   assign dq_oe    = oe_q & {4{~cs_n}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck;
         cs_q  <= cs_n;
      end
   end

   sfr_rx_frame #(.CNT_W(CNT_W)) u_rx (
      .clk, .rst_n, .cs_n, .sck_rise, .mode, .dq_in,
      .byte_done, .byte_data, .byte_idx, .nbytes, .on_boundary
   );

   sfr_reg_ctrl #(.NUM_SECTORS(NUM_SECTORS), .ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_ctrl (
      .clk, .rst_n, .cs_n, .cs_rise, .busy, .byte_done, .byte_data, .byte_idx,
      .nbytes, .on_boundary, .wel, .ext_addr, .rd_active, .rd_byte
   );

   sfr_tx_lanes u_tx (
      .clk, .rst_n, .cs_n, .sck_fall, .mode, .rd_active, .rd_byte,
      .dq_q(dq_out), .oe_q
   );
endmodule

// File: rtl/flash_reg_slave_chk.sv
module flash_reg_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       sck,
   input logic [3:0] dq_in,
   input logic [1:0] lane_mode,
   input logic       busy,
   input logic [3:0] dq_out,
   input logic [3:0] dq_oe,
   input logic       wel,
   input logic [7:0] ext_addr
);
   logic [3:0] exp_mask;
   assign exp_mask = (lane_mode == 2'b01) ? 4'b0011 :
                     (lane_mode == 2'b10) ? 4'b1111 : 4'b0010;

   p_oe_after_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe != 4'b0000) |-> !$past(cs_n));

   p_oe_lane_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe != 4'b0000) |-> (dq_oe == exp_mask));

   p_wel_set_on_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> ($past(cs_n) && !$past(cs_n, 2)));

   p_wel_clear_on_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wel) |-> ($past(cs_n) && !$past(cs_n, 2)));

   p_ext_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ext_addr) |-> $fell(wel));

   p_out_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((dq_oe != 4'b0000) && ($past(dq_oe) != 4'b0000) && !$stable(dq_out))
      |-> (!$past(sck) && $past(sck, 2)));
endmodule

bind flash_reg_slave flash_reg_slave_chk u_chk (.*);

// File: tb/tb_flash_reg_slave.sv
module tb_flash_reg_slave;
   localparam int HALF = 3;

   logic       clk = 1'b0;
   logic       rst_n, cs_n, sck, busy;
   logic [3:0] dq_in;
   logic [1:0] lane_mode;
   logic [3:0] dq_out, dq_oe;
   logic       wel;
   logic [7:0] ext_addr;

   always #5 clk = ~clk;

   flash_reg_slave dut (
      .clk, .rst_n, .cs_n, .sck, .dq_in, .lane_mode, .busy,
      .dq_out, .dq_oe, .wel, .ext_addr
   );

   int    vecs = 0, errs = 0;
   string phase = "R1";
   bit    running = 1'b0;

   // behavioural reference model
   bit         m_sck_q, m_cs_q, m_ok, m_wel, m_rd, m_rise, m_fall;
   logic [7:0] q[$];
   logic [7:0] m_cur, m_ext, m_rb;
   logic [1:0] m_lock [16];
   logic [3:0] m_oe, m_out;
   int         m_bits, m_ptr, m_w;

   function automatic logic [3:0] mask_of(input logic [1:0] m);
      return (m == 2'b01) ? 4'b0011 : (m == 2'b10) ? 4'b1111 : 4'b0010;
   endfunction
   function automatic int width_of(input logic [1:0] m);
      return (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
   endfunction

   task automatic model_commit();
      if (m_ok && m_bits == 0 && q.size() > 0) begin
         if (q[0] == 8'h06 && q.size() == 1) m_wel = 1'b1;
         else if (q[0] == 8'hC5 && q.size() == 2 && m_wel) begin
            m_ext = q[1]; m_wel = 1'b0;
         end else if (q[0] == 8'hE5 && q.size() == 5 && m_wel) begin
            if (!m_lock[q[1][7:4]][1]) m_lock[q[1][7:4]] = q[4][1:0];
            m_wel = 1'b0;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sck_q = 0; m_cs_q = 1; m_ok = 0; m_wel = 0; m_rd = 0;
         m_ext = 0; m_rb = 0; m_oe = 0; m_out = 0; m_bits = 0; m_ptr = 0;
         m_cur = 0; q.delete();
         for (int s = 0; s < 16; s++) m_lock[s] = 2'b00;
      end else begin
         m_w    = width_of(lane_mode);
         m_rise = !cs_n && sck && !m_sck_q;
         m_fall = !cs_n && !sck && m_sck_q;
         if (cs_n) begin
            if (!m_cs_q) model_commit();
            q.delete(); m_bits = 0; m_ok = 0; m_rd = 0; m_oe = 0; m_ptr = 0;
         end else begin
            if (m_rise) begin
               for (int k = m_w - 1; k >= 0; k--) m_cur = {m_cur[6:0], dq_in[k]};
               m_bits += m_w;
               if (m_bits == 8) begin
                  q.push_back(m_cur);
                  m_bits = 0;
                  if (q.size() == 1)
                     m_ok = !busy && (m_cur == 8'h06 || m_cur == 8'hC5 ||
                                      m_cur == 8'hE5 || m_cur == 8'hE8);
                  if (q.size() == 4 && m_ok && q[0] == 8'hE8) begin
                     m_rd = 1'b1;
                     m_rb = {6'b0, m_lock[q[1][7:4]]};
                  end
               end
            end
            if (m_fall && m_rd) begin
               m_oe  = mask_of(lane_mode);
               m_out = 4'b0000;
               for (int k = 0; k < m_w; k++) begin
                  if (m_w == 1) m_out[1] = m_rb[7 - m_ptr];
                  else          m_out[m_w - 1 - k] = m_rb[7 - m_ptr - k];
               end
               m_ptr = (m_ptr + m_w) % 8;
            end
         end
         m_sck_q = sck;
         m_cs_q  = cs_n;
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (running && rst_n) begin
         logic [3:0] eoe;
         eoe = m_oe & {4{~cs_n}};
         chk("wel", int'(wel), int'(m_wel));
         chk("ext_addr", int'(ext_addr), int'(m_ext));
         chk("dq_oe", int'(dq_oe), int'(eoe));
         chk("dq_out", int'(dq_out & eoe), int'(m_out & eoe));
      end
   end

   // stimulus
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic clk_chunk(input logic [3:0] d);
      dq_in = d;
      tick(HALF); sck = 1'b1;
      tick(HALF); sck = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      int w;
      logic [7:0] s;
      w = width_of(lane_mode);
      for (int p = 0; p < 8; p += w) begin
         s = b << p;
         if (w == 4)      clk_chunk(s[7:4]);
         else if (w == 2) clk_chunk({2'b00, s[7:6]});
         else             clk_chunk({3'b000, s[7]});
      end
   endtask

   task automatic xfer(input logic [7:0] bytes[$], input int extra);
      cs_n = 1'b0; tick(2);
      foreach (bytes[i]) send_byte(bytes[i]);
      for (int e = 0; e < extra; e++) clk_chunk(4'h0);
      tick(2); cs_n = 1'b1; tick(3);
   endtask

   task automatic set_wel();
      xfer('{8'h06}, 0);
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; dq_in = 4'h0; lane_mode = 2'b00; busy = 1'b0;
      tick(3); rst_n = 1'b1; running = 1'b1;
      phase = "R1"; tick(5);
      xfer('{8'hE8, 8'h00, 8'h00, 8'h00}, 16);
      phase = "R3"; set_wel();
      phase = "R4"; xfer('{8'hC5, 8'h5A}, 0);
      xfer('{8'hC5, 8'h77}, 0);
      phase = "R5"; set_wel();
      xfer('{8'hC5, 8'h33}, 4);
      xfer('{8'hC5, 8'h33, 8'h44}, 0);
      phase = "R2"; lane_mode = 2'b01; tick(2);
      xfer('{8'hC5, 8'hA3}, 0);
      lane_mode = 2'b11; tick(2);
      set_wel(); xfer('{8'hC5, 8'h3C}, 0);
      phase = "R6"; lane_mode = 2'b10; tick(2);
      set_wel(); xfer('{8'hE5, 8'h30, 8'h00, 8'h00, 8'hFD}, 0);
      xfer('{8'hE8, 8'h30, 8'h12, 8'h34}, 4);
      phase = "R8"; lane_mode = 2'b01; tick(2);
      xfer('{8'hE8, 8'h3F, 8'hFF, 8'hFF}, 8);
      lane_mode = 2'b00; tick(2);
      xfer('{8'hE8, 8'h35, 8'h00, 8'h01}, 16);
      phase = "R7"; set_wel();
      xfer('{8'hE5, 8'h50, 8'h00, 8'h00, 8'h02}, 0);
      set_wel();
      xfer('{8'hE5, 8'h50, 8'h00, 8'h00, 8'h01}, 0);
      xfer('{8'hE8, 8'h50, 8'h00, 8'h00}, 8);
      phase = "R9"; lane_mode = 2'b10; tick(2);
      xfer('{8'hE8, 8'h30, 8'h00, 8'h00}, 3);
      lane_mode = 2'b00; tick(2);
      phase = "R10"; busy = 1'b1;
      set_wel();
      xfer('{8'hE8, 8'h30, 8'h00, 8'h00}, 8);
      busy = 1'b0; set_wel(); busy = 1'b1;
      xfer('{8'hC5, 8'h99}, 0);
      busy = 1'b0;
      phase = "R11";
      xfer('{8'h9F, 8'h12}, 0);
      xfer('{8'hAB, 8'h06}, 8);
      xfer('{8'hC5, 8'h81}, 0);
      phase = "R7"; rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(2);
      xfer('{8'hE8, 8'h50, 8'h00, 8'h00}, 8);
      set_wel();
      xfer('{8'hE5, 8'h50, 8'h00, 8'h00, 8'h01}, 0);
      xfer('{8'hE8, 8'h50, 8'h00, 8'h00}, 8);
      running = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog %s: actual running expected done", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule